// File: doc/BRIEF.md
# Write-Zero-To-Clear Interrupt Status Register

This block keeps the primary interrupt status byte of a serial link controller. Receive and transmit logic present their events on a vector of request lines. Each line sets its own status bit, which then stays set until the host removes it. The host clears bits through a write-zero-to-clear convention: every position written as 0 is cleared, and every position written as 1 is left alone. Writing 0x7F therefore clears only bit 7, and writing 0xBF clears only bit 6.

Two positions of the byte do not store anything. They are extension bits, each showing whether any bit is set in one of two secondary status registers. They follow those registers and take no notice of host writes. A separate mask register lets the host stop chosen bits from raising the interrupt output. The host can then service status without a new interrupt being raised. A request line that is held high, such as one that reports a free transmit block, keeps its bit set across a clear for as long as the line stays high.

Top module: `w0c_int_status`

## Requirements
- R1: After reset all stored status bits are 0 and the mask register is 0x00. With both secondary inputs at zero, a status read returns 0x00 and irq_o is low.
- R2: A high request on evt_i[i] at a clock edge sets status bit i at that edge. The bit then stays set across later edges until a host clear removes it.
- R3: A host write with host_sel_i=0 clears, at that edge, every stored status bit whose write-data bit is 0. Every bit whose write-data bit is 1 is left unchanged.
- R4: A request at the same edge as a clear of the same bit wins, and the bit is 1 after that edge.
- R5: Status bit 0 reads as the OR of all bits of sec0_i, and status bit 1 reads as the OR of all bits of sec1_i. Both follow their inputs in the same cycle.
- R6: Host writes to the status register have no effect on bits 1 and 0, and evt_i[1:0] is ignored.
- R7: irq_o is high exactly when at least one status bit is 1 while the mask bit at the same position is 0. A mask bit of 1 disables its position.
- R8: A host write with host_sel_i=1 loads the mask register and leaves the status bits unchanged. A read returns the status byte when host_sel_i=0 and the mask byte when host_sel_i=1.
- R9: While a request line is held high, a clear of its bit leaves the bit reading 1 in the cycle right after the clearing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| evt_i | input | 8 | Event request lines, one per status bit |
| sec0_i | input | 8 | First secondary status register contents |
| sec1_i | input | 8 | Second secondary status register contents |
| host_we_i | input | 1 | Host write strobe |
| host_sel_i | input | 1 | Register select: 0 status, 1 mask |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Selected register contents |
| irq_o | output | 1 | Active-high combined interrupt |

## Verification
The bench builds the block with its defaults: an 8-bit status byte, 8-bit secondary registers, and the extension pair at bits 1 and 0. These defaults put every clear pattern, collisions on any bit, and every mask combination within reach of a few thousand random cycles. Directed cases cover the documented 0x7F and 0xBF writes, a held request meeting a clear, host writes that target the extension pair, and a fully masked register that still holds status.

// File: rtl/w0c_isr_pkg.sv
package w0c_isr_pkg;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_MASK   = 1'b1
  } host_sel_e;

  // Write-zero-to-clear update of one stored bit; a set request wins.
  function automatic logic w0c_next(input logic cur, input logic clr, input logic set);
    return (cur & ~clr) | set;
  endfunction

  // Enable term of one interrupt source.
  function automatic logic irq_term(input logic stat, input logic masked);
    return stat & ~masked;
  endfunction

endpackage

// File: rtl/w0c_event_bits.sv
module w0c_event_bits
  import w0c_isr_pkg::*;
#(
  parameter int W       = 8,
  parameter int EXT_LSB = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         wr_stat_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);

  localparam logic [W-1:0] EVT_MASK = ~(W'(2'b11) << EXT_LSB);

  logic [W-1:0] clr_vec;
  logic [W-1:0] set_vec;
  logic [W-1:0] q_d;

  assign clr_vec = wr_stat_i ? (~wdata_i & EVT_MASK) : '0;
  assign set_vec = evt_i & EVT_MASK;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign q_d[i] = w0c_next(q_o[i], clr_vec[i], set_vec[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_d;
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q_o & $past(q_o & ~clr_vec)) == $past(q_o & ~clr_vec)));

  // R4
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q_o & $past(set_vec)) == $past(set_vec)));

  // R3
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q_o & $past(clr_vec & ~set_vec)) == '0));

endmodule

// File: rtl/w0c_ext_mirror.sv
module w0c_ext_mirror #(
  parameter int SEC_W = 8
) (
  input  logic [1:0][SEC_W-1:0] sec_i,
  output logic [1:0]            ext_o
);

  for (genvar k = 0; k < 2; k++) begin : g_ext
    assign ext_o[k] = |sec_i[k];
  end

endmodule

// File: rtl/w0c_mask_gate.sv
module w0c_mask_gate
  import w0c_isr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_mask_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] status_i,
  output logic [W-1:0] mask_o,
  output logic         irq_o
);

  logic [W-1:0] live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_o <= '0;
    else if (wr_mask_i) mask_o <= wdata_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_term
    assign live[i] = irq_term(status_i[i], mask_o[i]);
  end

  assign irq_o = |live;

  // R7
  full_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_o) |-> !irq_o);

  // R7
  irq_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (status_i != '0));

endmodule

// File: rtl/w0c_int_status.sv
module w0c_int_status
  import w0c_isr_pkg::*;
#(
  parameter int STAT_W  = 8,
  parameter int SEC_W   = 8,
  parameter int EXT_LSB = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] evt_i,
  input  logic [SEC_W-1:0]  sec0_i,
  input  logic [SEC_W-1:0]  sec1_i,
  input  logic              host_we_i,
  input  logic              host_sel_i,
  input  logic [STAT_W-1:0] host_wdata_i,
  output logic [STAT_W-1:0] host_rdata_o,
  output logic              irq_o
);

  host_sel_e         sel;
  logic              wr_stat;
  logic              wr_mask;
  logic [STAT_W-1:0] evt_q;
  logic [1:0]        ext_w;
  logic [STAT_W-1:0] ext_vec;
  logic [STAT_W-1:0] status;
  logic [STAT_W-1:0] mask_q;

  assign sel     = host_sel_e'(host_sel_i);
  assign wr_stat = host_we_i && (sel == SEL_STATUS);
  assign wr_mask = host_we_i && (sel == SEL_MASK);

  w0c_event_bits #(.W(STAT_W), .EXT_LSB(EXT_LSB)) u_bits (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_i),
    .wr_stat_i(wr_stat),
    .wdata_i  (host_wdata_i),
    .q_o      (evt_q)
  );

  w0c_ext_mirror #(.SEC_W(SEC_W)) u_ext (
    .sec_i({sec1_i, sec0_i}),
    .ext_o(ext_w)
  );

  assign ext_vec = STAT_W'(ext_w) << EXT_LSB;
  assign status  = evt_q | ext_vec;

  w0c_mask_gate #(.W(STAT_W)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_mask_i(wr_mask),
    .wdata_i  (host_wdata_i),
    .status_i (status),
    .mask_o   (mask_q),
    .irq_o    (irq_o)
  );

  assign host_rdata_o = (sel == SEL_MASK) ? mask_q : status;

  // R6
  ext_ignores_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && $stable({sec1_i, sec0_i})) |-> $stable(ext_vec));

  // R8
  mask_write_keeps_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && (evt_i == '0)) |=> (evt_q == $past(evt_q)));

endmodule

// File: tb/w0c_int_status_test.sv
`timescale 1ns/1ps
module w0c_int_status_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt = '0, s0 = '0, s1 = '0, wd = '0;
  logic       we = 1'b0, sel = 1'b0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m_q = '0;
  logic [7:0] m_mask = '0;

  always #4 clk = ~clk;

  w0c_int_status uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .sec0_i(s0), .sec1_i(s1),
    .host_we_i(we), .host_sel_i(sel), .host_wdata_i(wd),
    .host_rdata_o(rdata), .irq_o(irq)
  );

  // Bench model: stored bits live at 7:2, extension pair at 1:0.
  function automatic logic [7:0] model_next(logic [7:0] q, logic [7:0] e,
                                            logic w, logic s, logic [7:0] d);
    logic [7:0] keep;
    keep = (w && !s) ? d : 8'hFF;
    return ((q & keep) | e) & 8'b1111_1100;
  endfunction

  function automatic logic [7:0] model_status(logic [7:0] q, logic [7:0] a, logic [7:0] b);
    return {q[7:2], (b != 0), (a != 0)};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_ports(string req);
    logic [7:0] st;
    st = model_status(m_q, s0, s1);
    chk(req, rdata, sel ? m_mask : st);
    chk(req, {7'd0, irq}, {7'd0, |(st & ~m_mask)});
  endtask

  // Called at a negedge: drive, take one edge, check at the next negedge.
  task automatic cyc(logic [7:0] e, logic [7:0] a, logic [7:0] b,
                     logic w, logic s, logic [7:0] d, string req);
    evt = e; s0 = a; s1 = b; we = w; sel = s; wd = d;
    @(posedge clk);
    m_q = model_next(m_q, e, w, s, d);
    if (w && s) m_mask = d;
    @(negedge clk);
    check_ports(req);
  endtask

  initial begin
    #(8 * 60000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5171));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", rdata, 8'h00);
    chk("R1", {7'd0, irq}, 8'h00);
    sel = 1'b1; #1;
    chk("R1", rdata, 8'h00);
    sel = 1'b0;
    rst_n = 1'b1;

    // R2 set and hold
    cyc(8'hC0, 0, 0, 0, 0, 0, "R2");
    chk("R2", rdata, 8'hC0);
    cyc(8'h00, 0, 0, 0, 0, 0, "R2");
    chk("R2", rdata, 8'hC0);
    // R3 documented patterns
    cyc(8'h00, 0, 0, 1, 0, 8'h7F, "R3");
    chk("R3", rdata, 8'h40);
    cyc(8'h00, 0, 0, 1, 0, 8'hBF, "R3");
    chk("R3", rdata, 8'h00);
    cyc(8'hFF, 0, 0, 0, 0, 0, "R2");
    cyc(8'h00, 0, 0, 1, 0, 8'hFF, "R3");
    chk("R3", rdata, 8'hFC);
    cyc(8'h00, 0, 0, 1, 0, 8'h00, "R3");
    chk("R3", rdata, 8'h00);
    // R4 collision
    cyc(8'h20, 0, 0, 1, 0, 8'h00, "R4");
    chk("R4", rdata, 8'h20);
    // R9 held request
    cyc(8'h10, 0, 0, 0, 0, 0, "R9");
    cyc(8'h10, 0, 0, 1, 0, 8'hEF, "R9");
    chk("R9", rdata & 8'h10, 8'h10);
    cyc(8'h00, 0, 0, 1, 0, 8'h00, "R9");
    chk("R9", rdata, 8'h00);
    // R5 / R6 extension bits
    cyc(8'h03, 8'h04, 8'h00, 0, 0, 0, "R5");
    chk("R5", rdata, 8'h01);
    cyc(8'h00, 8'h04, 8'h80, 1, 0, 8'h00, "R6");
    chk("R6", rdata, 8'h03);
    cyc(8'h00, 8'h00, 8'h80, 0, 0, 0, "R5");
    chk("R5", rdata, 8'h02);
    // R7 / R8 masking
    cyc(8'h08, 8'h00, 8'h80, 1, 1, 8'hFF, "R8");
    chk("R8", rdata, 8'hFF);
    chk("R7", {7'd0, irq}, 8'h00);
    sel = 1'b0; #1;
    chk("R8", rdata, 8'h0A);
    cyc(8'h00, 8'h00, 8'h00, 1, 1, 8'hF7, "R7");
    chk("R7", {7'd0, irq}, 8'h01);
    cyc(8'h00, 8'h00, 8'h00, 1, 1, 8'h08, "R7");
    chk("R7", {7'd0, irq}, 8'h00);

    // Random phase: all requirements against the model
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] e, a, b, d;
      logic w, s;
      e = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
      a = (($urandom % 3) == 0) ? 8'($urandom) : 8'h00;
      b = (($urandom % 3) == 0) ? 8'($urandom) : 8'h00;
      w = ($urandom % 3) == 0;
      s = ($urandom % 4) == 0;
      d = 8'($urandom);
      cyc(e, a, b, w, s, d, "R2 R3 R4 R5 R6 R7 R8");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule